// File: doc/BRIEF.md
# Trigger-Condition Bus Sequencer

This block is the control core of a slave-side parallel bus port. It watches a trigger vector and steps between three states: IDLE, READ and WRITE. The trigger vector joins three active-low control pins from the external bus master with a set of internal event flags from on-chip logic. The pins are a chip select, a read strobe and a write strobe. Each pin passes through a two-stage synchronizer before the sequencer uses it. The internal flags are taken to be synchronous to the block clock, so the sequencer uses them directly.

Four transition terms decide every state change. Each term is a product (AND) term over the trigger vector, written as a care mask and a polarity mask. The term is true when every cared trigger bit equals its polarity bit. Trigger bits that are not cared are ignored. A care mask of zero makes the term always true. The integration layer supplies the term table as static configuration inputs, so the same block can follow a different bus protocol without any change to the RTL.

When the sequencer enters READ, it raises a one-cycle start strobe for the read-data action. Entering WRITE raises the matching strobe for the write-data action. The data path that answers these strobes lies outside this block.

Top module: `trig_seq`

## Requirements
- R1: While rst_n is low at a rising clock edge, the state goes to IDLE (encoding 0). Both go strobes go low, and the synchronized pin copies go to their inactive (high) level.
- R2: In IDLE, when term 0 is true, the next state is READ (encoding 1). By default term 0 is cs_n low AND rd_n low.
- R3: In IDLE, when term 0 is false and term 1 is true, the next state is WRITE (encoding 2). By default term 1 is cs_n low AND wr_n low.
- R4: When term 0 and term 1 are both true in IDLE, the sequencer enters READ. Read has priority.
- R5: READ returns to IDLE when term 2 is true. WRITE returns to IDLE when term 3 is true. By default both terms are cs_n high.
- R6: In READ or WRITE, terms 0 and 1 have no effect. The state holds until that state's own exit term is true, so READ never goes directly to WRITE, and WRITE never goes directly to READ.
- R7: rd_go is high for exactly the first cycle in which the state is READ. wr_go is high for exactly the first cycle in which the state is WRITE. Neither strobe is high in IDLE.
- R8: A change on a control pin affects the state on the third rising edge after the change. A change on int_evt affects the state on the first rising edge after the change.
- R9: Term k sits at bits [k*N_TRIG +: N_TRIG] of term_care and term_pol. The term is true when, for every bit with care set to 1, the trigger bit equals the polarity bit. Bits with care set to 0 are ignored, and an all-zero care mask is always true.
- R10: The trigger vector bit layout is: bit 0 = synchronized cs_n, bit 1 = synchronized rd_n, bit 2 = synchronized wr_n, and bits 3 and up = int_evt[0] and up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | External chip select, active low, asynchronous |
| rd_n | input | 1 | External read enable, active low, asynchronous |
| wr_n | input | 1 | External write enable, active low, asynchronous |
| int_evt | input | N_INT | Internal event flags, synchronous to clk |
| term_care | input | N_TERM*N_TRIG | Care masks of the four transition terms |
| term_pol | input | N_TERM*N_TRIG | Polarity masks of the four transition terms |
| state | output | 2 | Current state: 0 IDLE, 1 READ, 2 WRITE |
| rd_go | output | 1 | One-cycle start strobe for the read-data action |
| wr_go | output | 1 | One-cycle start strobe for the write-data action |

## Verification
The assertions check, on every cycle, the properties that hold at any point in a run:
- the state code is legal;
- the sequencer never moves between READ and WRITE without passing through IDLE;
- each go strobe lasts one cycle, appears only in its own state, and never appears together with the other strobe;
- reset forces IDLE.

Other properties need chosen stimulus and exact cycle counts, so only the bench scenarios show them:
- the synchronizer latency of the pins against the single-edge latency of the internal events;
- read winning over write;
- cared and uncared trigger bits in a reprogrammed term, and the always-true empty term.

// File: rtl/trig_seq_pkg.sv
// Package: shared state encoding and trigger-vector bit positions for the
// trigger-condition bus sequencer. Assumes three external pins first in the
// trigger vector, internal event flags above them.
package trig_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } seq_state_t;

    localparam int N_PIN   = 3;
    localparam int N_TERM  = 4;

    // Trigger bit positions (R10)
    localparam int TB_CS = 0;
    localparam int TB_RD = 1;
    localparam int TB_WR = 2;

    // Term slots and their meaning
    localparam int TM_IDLE_TO_READ  = 0;
    localparam int TM_IDLE_TO_WRITE = 1;
    localparam int TM_READ_EXIT     = 2;
    localparam int TM_WRITE_EXIT    = 3;

endpackage

// File: rtl/trig_sync.sv
// Module: trig_sync
// Two-stage synchronizer bank for asynchronous active-low control pins.
// Assumes idle level of every pin is high; reset loads that idle level so no
// false trigger is seen while the pipeline fills.
module trig_sync #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_async,
    output logic [WIDTH-1:0] pin_sync
);

    genvar g;
    generate
        for (g = 0; g < WIDTH; g++) begin : g_bit
            logic stage1_q;
            logic stage2_q;

            // Shift each pin through two flops, resetting to the idle level
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage1_q <= 1'b1;
                    stage2_q <= 1'b1;
                end else begin
                    stage1_q <= pin_async[g];
                    stage2_q <= stage1_q;
                end
            end

            assign pin_sync[g] = stage2_q;
        end
    endgenerate

endmodule

// File: rtl/term_eval.sv
// Module: term_eval
// Evaluates a set of AND terms over the trigger vector. Each term is a care
// mask plus a polarity mask; a term is true when every cared bit equals its
// polarity. Purely combinational; assumes static or slowly changing masks.
module term_eval #(
    parameter int N_TRIG = 5,
    parameter int N_TERM = 4,
    localparam int TBL_W = N_TRIG * N_TERM
) (
    input  logic [N_TRIG-1:0] trig,
    input  logic [TBL_W-1:0]  care,
    input  logic [TBL_W-1:0]  pol,
    output logic [N_TERM-1:0] hit
);

    genvar k;
    generate
        for (k = 0; k < N_TERM; k++) begin : g_term
            logic [N_TRIG-1:0] care_k;
            logic [N_TRIG-1:0] pol_k;
            logic [N_TRIG-1:0] bit_ok;

            assign care_k = care[k*N_TRIG +: N_TRIG];
            assign pol_k  = pol[k*N_TRIG +: N_TRIG];

            // A bit passes when it is not cared or matches its polarity
            always_comb begin
                bit_ok = ~care_k | ~(trig ^ pol_k);
            end

            assign hit[k] = &bit_ok;
        end
    endgenerate

endmodule

// File: rtl/seq_fsm.sv
// Module: seq_fsm
// Three-state sequencer (IDLE/READ/WRITE) driven by pre-evaluated term hits.
// Read entry wins over write entry. Action strobes are registered and pulse
// in the first cycle of the state they belong to.
module seq_fsm
    import trig_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_TERM-1:0] hit,
    output seq_state_t        state_q,
    output logic              rd_go_q,
    output logic              wr_go_q
);

    seq_state_t state_d;

    // Next-state selection from the term hits of the current state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (hit[TM_IDLE_TO_READ])
                    state_d = ST_READ;
                else if (hit[TM_IDLE_TO_WRITE])
                    state_d = ST_WRITE;
            end
            ST_READ: begin
                if (hit[TM_READ_EXIT])
                    state_d = ST_IDLE;
            end
            ST_WRITE: begin
                if (hit[TM_WRITE_EXIT])
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and entry strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rd_go_q <= 1'b0;
            wr_go_q <= 1'b0;
        end else begin
            state_q <= state_d;
            rd_go_q <= (state_d == ST_READ)  && (state_q != ST_READ);
            wr_go_q <= (state_d == ST_WRITE) && (state_q != ST_WRITE);
        end
    end

endmodule

// File: rtl/trig_seq.sv
// Module: trig_seq (top)
// Trigger-condition bus sequencer. Builds the trigger vector from
// synchronized active-low pins and synchronous internal events, evaluates
// four configurable AND terms, and steps the IDLE/READ/WRITE state machine.
// Assumes int_evt is synchronous to clk and the term table is quasi-static.
module trig_seq
    import trig_seq_pkg::*;
#(
    parameter int N_INT = 2,
    localparam int N_TRIG = N_PIN + N_INT,
    localparam int TBL_W  = N_TERM * N_TRIG
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             rd_n,
    input  logic             wr_n,
    input  logic [N_INT-1:0] int_evt,
    input  logic [TBL_W-1:0] term_care,
    input  logic [TBL_W-1:0] term_pol,
    output logic [1:0]       state,
    output logic             rd_go,
    output logic             wr_go
);

    logic [N_PIN-1:0]  pin_raw;
    logic [N_PIN-1:0]  pin_s;
    logic [N_TRIG-1:0] trig;
    logic [N_TERM-1:0] hit;
    seq_state_t        st;

    // Gather pins in trigger-bit order
    always_comb begin
        pin_raw        = '0;
        pin_raw[TB_CS] = cs_n;
        pin_raw[TB_RD] = rd_n;
        pin_raw[TB_WR] = wr_n;
    end

    trig_sync #(.WIDTH(N_PIN)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (pin_raw),
        .pin_sync  (pin_s)
    );

    assign trig = {int_evt, pin_s};

    term_eval #(.N_TRIG(N_TRIG), .N_TERM(N_TERM)) u_eval (
        .trig (trig),
        .care (term_care),
        .pol  (term_pol),
        .hit  (hit)
    );

    seq_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (hit),
        .state_q (st),
        .rd_go_q (rd_go),
        .wr_go_q (wr_go)
    );

    assign state = st;

endmodule

// File: rtl/trig_seq_chk.sv
// Module: trig_seq_chk
// Port-level property checker for trig_seq, attached by bind.
module trig_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] state,
    input logic       rd_go,
    input logic       wr_go
);

    // R1: reset forces IDLE with strobes low
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (state == 2'd0) && !rd_go && !wr_go);

    // R6: state code stays legal
    a_r6_legal_state: assert property (@(posedge clk) disable iff (!rst_n)
        state != 2'd3);

    // R6: no direct READ to WRITE
    a_r6_no_read_to_write: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'd1) |=> (state != 2'd2));

    // R6: no direct WRITE to READ
    a_r6_no_write_to_read: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'd2) |=> (state != 2'd1));

    // R7: each strobe lasts one cycle
    a_r7_rd_go_single: assert property (@(posedge clk) disable iff (!rst_n)
        rd_go |=> !rd_go);
    a_r7_wr_go_single: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |=> !wr_go);

    // R7: strobes belong to their own state and never overlap
    a_r7_rd_go_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_go |-> (state == 2'd1));
    a_r7_wr_go_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |-> (state == 2'd2));
    a_r7_go_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({rd_go, wr_go}) <= 1);

    // R7: entering READ from elsewhere raises rd_go
    a_r7_rd_go_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (state != 2'd1) |=> ((state == 2'd1) == rd_go));

endmodule

bind trig_seq trig_seq_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .state (state),
    .rd_go (rd_go),
    .wr_go (wr_go)
);

// File: tb/sim_trig_seq.sv
// Directed bench for trig_seq: one task per scenario, each self-checking.
module sim_trig_seq;

    localparam int N_INT  = 2;
    localparam int N_TRIG = 3 + N_INT;
    localparam int TBL_W  = 4 * N_TRIG;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cs_n = 1'b1;
    logic             rd_n = 1'b1;
    logic             wr_n = 1'b1;
    logic [N_INT-1:0] int_evt = '0;
    logic [TBL_W-1:0] term_care;
    logic [TBL_W-1:0] term_pol;
    logic [1:0]       state;
    logic             rd_go;
    logic             wr_go;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    trig_seq #(.N_INT(N_INT)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .int_evt(int_evt), .term_care(term_care), .term_pol(term_pol),
        .state(state), .rd_go(rd_go), .wr_go(wr_go)
    );

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_term(input int k, input logic [N_TRIG-1:0] c, input logic [N_TRIG-1:0] p);
        term_care[k*N_TRIG +: N_TRIG] = c;
        term_pol[k*N_TRIG +: N_TRIG]  = p;
    endtask

    // Default protocol: R10 bit order cs=0, rd=1, wr=2, evt=3..
    task automatic load_defaults();
        set_term(0, 5'b00011, 5'b00000);
        set_term(1, 5'b00101, 5'b00000);
        set_term(2, 5'b00001, 5'b00001);
        set_term(3, 5'b00001, 5'b00001);
    endtask

    task automatic pins(input logic c, input logic r, input logic w);
        cs_n = c; rd_n = r; wr_n = w;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        pins(1'b0, 1'b0, 1'b1);
        cyc(2);
        check("R1 state", {2'b0, state}, 4'd0);
        check("R1 strobes", {2'b0, rd_go, wr_go}, 4'd0);
        rst_n = 1'b1;
        // synchronizer reset to high: first post-reset edge sees no trigger
        cyc(1);
        check("R1 sync idle after reset", {2'b0, state}, 4'd0);
        pins(1'b1, 1'b1, 1'b1);
        cyc(4);
        check("R1 settle idle", {2'b0, state}, 4'd0);
    endtask

    task automatic t_read_latency();
        pins(1'b0, 1'b0, 1'b1);
        cyc(2);
        check("R8 no change after 2 edges", {2'b0, state}, 4'd0);
        cyc(1);
        check("R2 enter READ on 3rd edge", {2'b0, state}, 4'd1);
        check("R7 rd_go pulse", {2'b0, rd_go, wr_go}, 4'b0010);
        cyc(1);
        check("R7 rd_go one cycle", {3'b0, rd_go}, 4'd0);
        pins(1'b1, 1'b1, 1'b1);
        cyc(2);
        check("R5 still READ before sync", {2'b0, state}, 4'd1);
        cyc(1);
        check("R5 READ exit on cs high", {2'b0, state}, 4'd0);
        check("R7 no strobe in IDLE", {2'b0, rd_go, wr_go}, 4'd0);
    endtask

    task automatic t_write();
        pins(1'b0, 1'b1, 1'b0);
        cyc(3);
        check("R3 enter WRITE", {2'b0, state}, 4'd2);
        check("R7 wr_go pulse", {2'b0, rd_go, wr_go}, 4'b0001);
        cyc(1);
        check("R7 wr_go one cycle", {3'b0, wr_go}, 4'd0);
        // R6: read request while writing is ignored
        pins(1'b0, 1'b0, 1'b1);
        cyc(5);
        check("R6 hold WRITE under read cond", {2'b0, state}, 4'd2);
        check("R6 no rd_go in WRITE", {3'b0, rd_go}, 4'd0);
        pins(1'b1, 1'b1, 1'b1);
        cyc(3);
        check("R5 WRITE exit", {2'b0, state}, 4'd0);
    endtask

    task automatic t_priority_hold();
        pins(1'b0, 1'b0, 1'b0);
        cyc(3);
        check("R4 read wins", {2'b0, state}, 4'd1);
        check("R4 only rd_go", {2'b0, rd_go, wr_go}, 4'b0010);
        // R9: uncared internal events have no effect
        int_evt = 2'b11;
        pins(1'b0, 1'b1, 1'b0);
        cyc(5);
        check("R6/R9 hold READ", {2'b0, state}, 4'd1);
        check("R6 no wr_go in READ", {3'b0, wr_go}, 4'd0);
        int_evt = 2'b00;
        pins(1'b1, 1'b1, 1'b1);
        cyc(3);
        check("R5 back to IDLE", {2'b0, state}, 4'd0);
    endtask

    task automatic t_internal_term();
        // term 0 also cares int_evt[0] (bit 3) high
        set_term(0, 5'b01011, 5'b01000);
        pins(1'b0, 1'b0, 1'b1);
        cyc(4);
        check("R9 cared evt blocks READ", {2'b0, state}, 4'd0);
        int_evt = 2'b10;
        cyc(1);
        check("R9 wrong evt bit blocks READ", {2'b0, state}, 4'd0);
        int_evt = 2'b01;
        cyc(1);
        check("R8 evt acts on first edge", {2'b0, state}, 4'd1);
        check("R10 evt0 at bit 3 rd_go", {3'b0, rd_go}, 4'd1);
        int_evt = 2'b00;
        pins(1'b1, 1'b1, 1'b1);
        cyc(3);
        check("R5 exit after custom read", {2'b0, state}, 4'd0);
        load_defaults();
        cyc(1);
    endtask

    task automatic t_empty_care();
        set_term(1, 5'b00000, 5'b00000);
        cyc(1);
        check("R9 empty term always true", {2'b0, state}, 4'd2);
        check("R3 wr_go on empty term", {3'b0, wr_go}, 4'd1);
        load_defaults();
        cyc(1);
        check("R5 cs high exits WRITE", {2'b0, state}, 4'd0);
        cyc(2);
        check("R3 defaults restored IDLE", {2'b0, state}, 4'd0);
    endtask

    initial begin
        load_defaults();
        cyc(1);
        t_reset();
        t_read_latency();
        t_write();
        t_priority_hold();
        t_internal_term();
        t_empty_care();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule